// File: doc/BRIEF.md
# Buffered Multi-Byte Serial Master

This block is a three-wire synchronous serial master that runs a whole transfer of several bytes with no help from a processor per byte. Software loads a small byte buffer through a single-cycle register port, sets the byte count and the inter-byte gap, and enables the engine. It then starts the transfer with a write strobe to the shift register. The data value of that write is irrelevant.

The engine reads each transmit byte from the buffer. It shifts the byte out on SO, most significant bit first, and at the same time collects a byte from SI. The received byte is stored back into the buffer location the transmit byte came from. Between bytes, SCK rests high for a programmed gap while the buffer is updated. A busy flag covers the whole run and is the definitive end marker. A completion interrupt is raised once, when the run ends. The interrupt stays set until software clears it with a separate strobe.

Top module: `auto_serial_xfer`

## Requirements
- R1: After reset, sck is 1, so is 0, busy is 0 and irq is 0.
- R2: A shift_wr pulse starts a transfer only when ser_en is 1 and busy is 0. A pulse while ser_en is 0 leaves busy at 0 and produces no SCK edges.
- R3: Each byte is sent on so with bit 7 first and bit 0 last. so changes only together with a falling SCK edge. si is sampled at each rising SCK edge, and the first sample becomes bit 7 of the received byte.
- R4: Bytes are taken from buffer addresses 0, 1, … n-1 in that order. Each received byte overwrites the address its transmit byte came from. Addresses n and above are left unchanged.
- R5: xfer_len is a 6-bit byte count n. A value of 0 acts as 1 and values above 32 act as 32. A run produces exactly 8·n falling SCK edges.
- R6: Each SCK half-period is HALF_DIV clock cycles. Between two bytes, SCK stays high for exactly (2·g+1)·HALF_DIV cycles, where g is the 4-bit gap_len and a gap_len of 0 acts as 1. SCK is high whenever busy is 0.
- R7: busy rises at the clock edge that accepts shift_wr. It stays set until the last byte completes. shift_wr pulses while busy is 1 are ignored.
- R8: irq rises exactly at the edge where busy falls, once per run. A pulse on irq_clr clears it.
- R9: so is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial engine enable |
| xfer_len | input | 6 | Byte count of a run |
| gap_len | input | 4 | Inter-byte gap in SCK periods |
| shift_wr | input | 1 | Shift register write strobe, starts a run |
| irq_clr | input | 1 | Clears the completion interrupt |
| host_addr | input | 5 | Buffer address for the register port |
| host_wr | input | 1 | Buffer write enable |
| host_wdata | input | 8 | Buffer write data |
| host_rdata | output | 8 | Buffer read data at host_addr |
| si | input | 1 | Serial data in |
| sck | output | 1 | Serial clock, idles high |
| so | output | 1 | Serial data out |
| busy | output | 1 | Run in progress |
| irq | output | 1 | Completion interrupt flag |

## Verification
The bench measures every SCK high period. A gap counter that is off by one shows up as a high run that is neither HALF_DIV nor the expected gap length. It also uses counts of 0 and 40. A design that did not clamp the count would run zero bytes or wrap the address pointer, so the falling-edge count and the untouched address would both be wrong. A second shift_wr during a run checks that the run is not restarted, since a restart would add edges. After each run the bench reads the whole buffer back. This catches received bytes written to the wrong address, or bits collected in reverse order. It also checks that so drops low and irq rises on the exact cycle that busy falls.

// File: rtl/asx_pkg.sv
package asx_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_LOAD  = 2'd1,
    S_SHIFT = 2'd2,
    S_GAP   = 2'd3
  } asx_state_t;

  // Effective byte count: 0 behaves as 1, anything past depth saturates.
  function automatic int unsigned clamp_len(int unsigned len, int unsigned depth);
    if (len == 0) return 1;
    if (len > depth) return depth;
    return len;
  endfunction

  // Gap counter preload so that SCK rests high for (2*g+1)*half cycles.
  function automatic int unsigned gap_load(int unsigned g, int unsigned half);
    int unsigned eff;
    eff = (g == 0) ? 1 : g;
    return eff * 2 * half - 1;
  endfunction

endpackage

// File: rtl/asx_buffer.sv
module asx_buffer #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          eng_wr,
  input  logic [AW-1:0] eng_addr,
  input  logic [7:0]    eng_wdata,
  output logic [7:0]    eng_rdata
);
  logic [7:0] mem [DEPTH];

  // Engine write takes precedence over a host write in the same cycle.
  always_ff @(posedge clk) begin
    if (eng_wr) mem[eng_addr] <= eng_wdata;
    else if (host_wr) mem[host_addr] <= host_wdata;
  end

  assign host_rdata = mem[host_addr];
  assign eng_rdata  = mem[eng_addr];
endmodule

// File: rtl/asx_shifter.sv
module asx_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       si,
  output logic       sck,
  output logic       so,
  output logic [7:0] rx_byte,
  output logic       byte_done
);
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HW-1:0] HMAX = HW'(HALF_DIV - 1);

  logic          active;
  logic          sck_r;
  logic          so_r;
  logic [HW-1:0] hcnt;
  logic [2:0]    bitn;
  logic [7:0]    sh_tx;
  logic [7:0]    sh_rx;
  logic          half_end;

  assign half_end  = (hcnt == HMAX);
  assign byte_done = active && sck_r && half_end && (bitn == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sck_r  <= 1'b1;
      so_r   <= 1'b0;
      hcnt   <= '0;
      bitn   <= '0;
      sh_tx  <= '0;
      sh_rx  <= '0;
    end else if (start) begin
      active <= 1'b1;
      sck_r  <= 1'b0;
      so_r   <= tx_byte[7];
      sh_tx  <= {tx_byte[6:0], 1'b0};
      hcnt   <= '0;
      bitn   <= '0;
    end else if (active) begin
      if (half_end) begin
        hcnt <= '0;
        if (!sck_r) begin
          sck_r <= 1'b1;
          sh_rx <= {sh_rx[6:0], si};
        end else if (bitn == 3'd7) begin
          active <= 1'b0;
          so_r   <= 1'b0;
        end else begin
          sck_r <= 1'b0;
          so_r  <= sh_tx[7];
          sh_tx <= {sh_tx[6:0], 1'b0};
          bitn  <= bitn + 3'd1;
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

  assign sck     = sck_r;
  assign so      = so_r;
  assign rx_byte = sh_rx;
endmodule

// File: rtl/asx_seq.sv
module asx_seq
  import asx_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int HALF_DIV = 2,
  parameter int AW       = $clog2(DEPTH),
  parameter int CW       = AW + 1,
  parameter int IW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_en,
  input  logic [CW-1:0] xfer_len,
  input  logic [IW-1:0] gap_len,
  input  logic          shift_wr,
  input  logic          irq_clr,
  input  logic          byte_done,
  output logic          start,
  output logic [AW-1:0] eng_addr,
  output logic          eng_wr,
  output logic          gap_active,
  output logic          busy,
  output logic          irq
);
  localparam int GW = $clog2(((1 << IW) - 1) * 2 * HALF_DIV + 1);

  asx_state_t    state;
  logic [AW-1:0] ptr;
  logic [AW-1:0] last;
  logic [GW-1:0] gcnt;
  logic [GW-1:0] gload;
  logic          busy_r;
  logic          irq_r;
  logic          run_end;

  assign run_end = (state == S_SHIFT) && byte_done && (ptr == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ptr    <= '0;
      last   <= '0;
      gcnt   <= '0;
      gload  <= '0;
      busy_r <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (shift_wr && ser_en) begin
          busy_r <= 1'b1;
          ptr    <= '0;
          last   <= AW'(clamp_len(32'(xfer_len), DEPTH) - 1);
          gload  <= GW'(gap_load(32'(gap_len), HALF_DIV));
          state  <= S_LOAD;
        end
        S_LOAD: state <= S_SHIFT;
        S_SHIFT: if (byte_done) begin
          if (ptr == last) begin
            busy_r <= 1'b0;
            state  <= S_IDLE;
          end else begin
            gcnt  <= gload;
            state <= S_GAP;
          end
        end
        S_GAP: begin
          if (gcnt == GW'(1)) begin
            ptr   <= ptr + AW'(1);
            state <= S_LOAD;
          end else begin
            gcnt <= gcnt - GW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_r <= 1'b0;
    else if (run_end) irq_r <= 1'b1;
    else if (irq_clr) irq_r <= 1'b0;
  end

  assign start      = (state == S_LOAD);
  assign eng_wr     = (state == S_SHIFT) && byte_done;
  assign eng_addr   = ptr;
  assign gap_active = (state == S_GAP);
  assign busy       = busy_r;
  assign irq        = irq_r;
endmodule

// File: rtl/auto_serial_xfer.sv
module auto_serial_xfer #(
  parameter int DEPTH    = 32,
  parameter int HALF_DIV = 2,
  parameter int AW       = $clog2(DEPTH),
  parameter int CW       = AW + 1,
  parameter int IW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_en,
  input  logic [CW-1:0] xfer_len,
  input  logic [IW-1:0] gap_len,
  input  logic          shift_wr,
  input  logic          irq_clr,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          si,
  output logic          sck,
  output logic          so,
  output logic          busy,
  output logic          irq
);
  logic          start;
  logic          byte_done;
  logic          gap_active;
  logic          eng_wr;
  logic [AW-1:0] eng_addr;
  logic [7:0]    eng_rdata;
  logic [7:0]    rx_byte;

  asx_seq #(
    .DEPTH(DEPTH), .HALF_DIV(HALF_DIV), .AW(AW), .CW(CW), .IW(IW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .xfer_len(xfer_len),
    .gap_len(gap_len), .shift_wr(shift_wr), .irq_clr(irq_clr),
    .byte_done(byte_done), .start(start), .eng_addr(eng_addr),
    .eng_wr(eng_wr), .gap_active(gap_active), .busy(busy), .irq(irq)
  );

  asx_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(eng_rdata),
    .si(si), .sck(sck), .so(so), .rx_byte(rx_byte), .byte_done(byte_done)
  );

  asx_buffer #(.DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_wr(eng_wr), .eng_addr(eng_addr), .eng_wdata(rx_byte),
    .eng_rdata(eng_rdata)
  );
endmodule

// File: rtl/asx_checker.sv
module asx_checker (
  input logic clk,
  input logic rst_n,
  input logic ser_en,
  input logic shift_wr,
  input logic irq_clr,
  input logic sck,
  input logic so,
  input logic busy,
  input logic irq,
  input logic byte_done,
  input logic gap_active
);
  // R9: serial output parked low outside a run
  a_r9_so_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !so);

  // R6: clock line rests high when idle
  a_r6_sck_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck);

  // R6: clock line rests high through each gap
  a_r6_gap_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> sck);

  // R8: interrupt rises only as busy falls
  a_r8_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));

  // R8: clear strobe drops the flag when no run is ending
  a_r8_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !busy) |=> !irq);

  // R2: strobe while disabled starts nothing
  a_r2_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_wr && !ser_en && !busy) |=> !busy);

  // R7: busy only ends on a completed byte
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !byte_done) |=> busy);
endmodule

bind auto_serial_xfer asx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .shift_wr(shift_wr),
  .irq_clr(irq_clr), .sck(sck), .so(so), .busy(busy), .irq(irq),
  .byte_done(byte_done), .gap_active(gap_active)
);

// File: tb/auto_serial_xfer_test.sv
`timescale 1ns/1ps
module auto_serial_xfer_test;
  localparam int HD = 2;
  localparam int NV = 6;
  // {len[5:0], gap[3:0], poke}
  localparam logic [10:0] VECS [NV] = '{
    {6'd6,  4'd2,  1'b0},
    {6'd1,  4'd1,  1'b0},
    {6'd3,  4'd0,  1'b1},
    {6'd0,  4'd3,  1'b0},
    {6'd40, 4'd1,  1'b0},
    {6'd5,  4'd15, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_en = 1'b0, shift_wr = 1'b0, irq_clr = 1'b0, host_wr = 1'b0;
  logic [5:0] xfer_len = '0;
  logic [3:0] gap_len = '0;
  logic [4:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic si = 1'b0, sck, so, busy, irq;

  auto_serial_xfer #(.HALF_DIV(HD)) uut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .xfer_len(xfer_len),
    .gap_len(gap_len), .shift_wr(shift_wr), .irq_clr(irq_clr),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .si(si), .sck(sck), .so(so), .busy(busy), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int cur_vec = 0, cur_gap = 1;
  logic mon_clr = 1'b0;
  int fcnt, rcnt, so_bad, run, gap_runs, bad_runs, irq_rises;
  logic seen_fall, prev_sck, prev_irq;
  logic [7:0] so_acc;

  function automatic logic [7:0] txp(int v, int a);
    return 8'((a * 29 + v * 7 + 91) & 255);
  endfunction
  function automatic logic [7:0] rxp(int v, int b);
    return 8'(8'hC3 ^ 8'((b * 13) & 255) ^ 8'(v));
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Slave model and line monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_clr) begin
      fcnt = 0; rcnt = 0; so_bad = 0; run = 0; gap_runs = 0; bad_runs = 0;
      irq_rises = 0; seen_fall = 1'b0; prev_sck = 1'b1; prev_irq = 1'b0; so_acc = '0;
    end else begin
      if (irq && !prev_irq) irq_rises++;
      if (prev_sck && !sck) begin
        if (seen_fall) begin
          if (run == HD) ;
          else if (run == (2 * cur_gap + 1) * HD) gap_runs++;
          else bad_runs++;
        end
        seen_fall = 1'b1;
        run = 0;
        si = rxp(cur_vec, fcnt / 8)[7 - (fcnt % 8)];
        fcnt++;
      end else if (!prev_sck && sck) begin
        so_acc = {so_acc[6:0], so};
        rcnt++;
        if (rcnt % 8 == 0 && so_acc != txp(cur_vec, rcnt / 8 - 1)) so_bad++;
      end
      if (busy && sck) run++;
      prev_sck = sck;
      prev_irq = irq;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic clr_mon();
    @(posedge clk); #1 mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 shift_wr = 1'b1;
    @(posedge clk); #1 shift_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(posedge clk); #1 irq_clr = 1'b1;
    @(posedge clk); #1 irq_clr = 1'b0;
  endtask

  task automatic fill(int v);
    for (int a = 0; a < 32; a++) begin
      @(posedge clk); #1 host_addr = 5'(a); host_wdata = txp(v, a); host_wr = 1'b1;
    end
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk); host_addr = 5'(a); #1 d = host_rdata;
  endtask

  task automatic run_vec(int v);
    int n, g, wait_c, bad_rx;
    logic [7:0] d;
    n = (VECS[v][10:5] == 0) ? 1 : ((VECS[v][10:5] > 32) ? 32 : int'(VECS[v][10:5]));
    g = (VECS[v][4:1] == 0) ? 1 : int'(VECS[v][4:1]);
    cur_vec = v; cur_gap = g;
    fill(v);
    xfer_len = VECS[v][10:5]; gap_len = VECS[v][4:1]; ser_en = 1'b1;
    clr_mon();
    pulse_start();
    check($sformatf("R7 busy after start v%0d", v), int'(busy), 1);
    if (VECS[v][0]) begin
      repeat (40) @(posedge clk);
      pulse_start();
    end
    wait_c = 0;
    do begin @(negedge clk); wait_c++; end while (busy && wait_c < 20000);
    check($sformatf("R8 irq as busy falls v%0d", v), int'(irq), 1);
    check($sformatf("R9 so low at end v%0d", v), int'(so), 0);
    repeat (3) @(negedge clk);
    check($sformatf("R5 falling edges v%0d", v), fcnt, 8 * n);
    check($sformatf("R3 so bytes wrong v%0d", v), so_bad, 0);
    check($sformatf("R6 bad high runs v%0d", v), bad_runs, 0);
    check($sformatf("R6 gap runs v%0d", v), gap_runs, n - 1);
    check($sformatf("R8 irq rises v%0d", v), irq_rises, 1);
    bad_rx = 0;
    for (int b = 0; b < n; b++) begin
      rd(b, d);
      if (d != rxp(v, b)) bad_rx++;
    end
    check($sformatf("R4 received bytes wrong v%0d", v), bad_rx, 0);
    if (n < 32) begin
      rd(n, d);
      check($sformatf("R4 addr n untouched v%0d", v), int'(d), int'(txp(v, n)));
    end
    pulse_clr();
    @(negedge clk);
    check($sformatf("R8 irq cleared v%0d", v), int'(irq), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 sck reset", int'(sck), 1);
    check("R1 so reset", int'(so), 0);
    check("R1 busy reset", int'(busy), 0);
    check("R1 irq reset", int'(irq), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R2: start strobe while disabled
    ser_en = 1'b0; xfer_len = 6'd4; gap_len = 4'd1;
    clr_mon();
    pulse_start();
    repeat (30) @(negedge clk);
    check("R2 busy stays low", int'(busy), 0);
    check("R2 no sck edges", fcnt, 0);
    check("R2 irq stays low", int'(irq), 0);

    // R2: same settings once enabled do start
    ser_en = 1'b1;
    pulse_start();
    check("R2 enabled start", int'(busy), 1);
    while (busy) @(negedge clk);
    check("R5 four bytes", fcnt, 32);
    pulse_clr();

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule